// File: doc/BRIEF.md
# Protected MII Converter Configuration Registers

This block is the software-visible control bank for a multi-port media-independent-interface converter. A 32-bit register bus sets, for each converter port, its interface type (MII, RMII or RGMII), line speed and duplex. The bus also drives a reset-release bit per port and two switch-side override masks. The decoded per-port fields and release bits leave the block as flop outputs. Converter datapaths take them from there.

The switch-mode selector chooses how the converter ports are steered. A stray write to it could reroute live links, so it is guarded. Software must first write a four-word key to the command register. After that, exactly one write to the mode register is accepted, and then the guard closes again. A write that is refused, or an illegal mode value, sets a sticky protection-error flag that software can read back.

Reads are registered. Read data appears on the clock after the read strobe and is zero at every other time.

Top module: `mcr_regbank`

## Requirements
- R1: After reset, every register reads zero. All port enables are low, so every port is held in reset, and all exported fields are zero.
- R2: A read of offset 0x4 returns the ID_CODE parameter. Read data is valid in the cycle after the read strobe and is zero in any cycle that follows a cycle without the read strobe.
- R3: Four consecutive writes to the command register (offset 0x0) with the values 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001 open the guard. A read of offset 0x0 returns the open state in bit 0 and the protection-error flag in bit 1, with all other bits zero.
- R4: A command write that does not match the next expected key restarts the key sequence. If that write is 0x000000A5, it counts as the first key. Any command write while the guard is open closes it again.
- R5: While the guard is open, one write to the mode register (offset 0x20) with a legal value stores bits [4:0] and closes the guard. A second write is then refused.
- R6: A write to the mode register while the guard is closed leaves the mode unchanged and sets the protection-error flag. The flag stays set until reset.
- R7: The only legal mode values are 0x00-0x03, 0x08-0x0B and 0x10-0x13. An illegal value written while the guard is open is discarded, sets the protection-error flag, and closes the guard.
- R8: The control word of port p is at offset 0x100+4*p. Its fields are: bits [1:0] speed (0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s), bits [3:2] interface (0 = MII, 1 = RMII, 2 = RGMII), bit 8 full duplex, and RGMII in-band status in bits [15:12]. Other bits read zero. The speed, interface and duplex fields drive conv_speed_o[2p+:2], conv_if_o[2p+:2] and conv_fulld_o[p] from the cycle after the write.
- R9: At offset 0x114, bit p releases port p from reset. conv_enable_o[p] follows it from the cycle after the write. Bits at and above NUM_PORTS read zero.
- R10: Offsets 0x304 and 0x308 hold per-port switch speed and duplex override masks in bits [NUM_PORTS-1:0]. They are exported on sw_speed_ovr_o and sw_dup_ovr_o, and their other bits read zero.
- R11: Any other offset, including misaligned ones and port words at or above NUM_PORTS, reads zero. Reads and writes to such offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sw_mode_o | output | 5 | Current switch-mode selector |
| conv_speed_o | output | 2*NUM_PORTS | Per-port speed code |
| conv_if_o | output | 2*NUM_PORTS | Per-port interface type code |
| conv_fulld_o | output | NUM_PORTS | Per-port full-duplex flag |
| conv_enable_o | output | NUM_PORTS | Per-port reset release |
| sw_speed_ovr_o | output | NUM_PORTS | Switch speed override mask |
| sw_dup_ovr_o | output | NUM_PORTS | Switch duplex override mask |

## Verification
The bench builds the bank with NUM_PORTS = 3 and a non-trivial ID_CODE. With three ports, offset 0x10C becomes an unmapped port slot directly beside live ones, so the address decoder's upper bound is tested. The reduced size also keeps every aligned offset up to 0x3FC within reach of repeated full read sweeps against a bench-side register image. All 32 mode values are tried, each from a fresh reset behind a complete key. Every speed, interface and duplex combination on every port is driven with all reserved bits set, and every release-mask value is applied.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned OFS_CMD   = 32'h000;
  localparam int unsigned OFS_ID    = 32'h004;
  localparam int unsigned OFS_MODE  = 32'h020;
  localparam int unsigned OFS_PORT0 = 32'h100;
  localparam int unsigned OFS_REL   = 32'h114;
  localparam int unsigned OFS_SWSPD = 32'h304;
  localparam int unsigned OFS_SWDUP = 32'h308;

  localparam int KEY_LEN = 4;
  localparam int STEP_W  = $clog2(KEY_LEN);
  localparam logic [31:0] CTRL_MASK = 32'h0000_F10F;

  function automatic logic [31:0] key_word(input logic [STEP_W-1:0] idx);
    case (idx)
      2'd0:    key_word = 32'h0000_00A5;
      2'd2:    key_word = 32'h0000_FFFE;
      default: key_word = 32'h0000_0001;
    endcase
  endfunction

  function automatic logic mode_ok(input logic [4:0] v);
    mode_ok = !v[2] && !(v[4] && v[3]);
  endfunction
endpackage

// File: rtl/mcr_key_guard.sv
module mcr_key_guard
  import mcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic        mode_we,
  input  logic [31:0] wdata,
  output logic        open_q,
  output logic        perr_q,
  output logic        mode_take
);
  logic [STEP_W-1:0] step_q;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_LEN - 1);

  assign mode_take = mode_we && open_q && mode_ok(wdata[4:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      open_q <= 1'b0;
      perr_q <= 1'b0;
    end else if (cmd_we) begin
      open_q <= 1'b0;
      if (wdata == key_word(step_q)) begin
        if (step_q == LAST) begin
          step_q <= '0;
          open_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else begin
        step_q <= (wdata == key_word('0)) ? STEP_W'(1) : '0;
      end
    end else if (mode_we) begin
      open_q <= 1'b0;
      if (!mode_take) perr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mcr_port_bank.sv
module mcr_port_bank
  import mcr_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int IDX_W     = 3
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctrl_we,
  input  logic [IDX_W-1:0]        ctrl_idx,
  input  logic                    rel_we,
  input  logic [31:0]             wdata,
  output logic [32*NUM_PORTS-1:0] ctrl_flat,
  output logic [NUM_PORTS-1:0]    rel_q,
  output logic [2*NUM_PORTS-1:0]  conv_speed_o,
  output logic [2*NUM_PORTS-1:0]  conv_if_o,
  output logic [NUM_PORTS-1:0]    conv_fulld_o
);
  always_ff @(posedge clk) begin
    if (rst)         rel_q <= '0;
    else if (rel_we) rel_q <= wdata[NUM_PORTS-1:0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (ctrl_we && ctrl_idx == IDX_W'(p))
        word_q <= wdata & CTRL_MASK;
    end
    assign ctrl_flat[32*p +: 32]  = word_q;
    assign conv_speed_o[2*p +: 2] = word_q[1:0];
    assign conv_if_o[2*p +: 2]    = word_q[3:2];
    assign conv_fulld_o[p]        = word_q[8];
  end
endmodule

// File: rtl/mcr_regbank.sv
module mcr_regbank
  import mcr_pkg::*;
#(
  parameter int          NUM_PORTS = 5,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] ID_CODE   = 32'h0000_4D43
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic                   bus_we,
  input  logic                   bus_re,
  output logic [31:0]            bus_rdata,
  output logic [4:0]             sw_mode_o,
  output logic [2*NUM_PORTS-1:0] conv_speed_o,
  output logic [2*NUM_PORTS-1:0] conv_if_o,
  output logic [NUM_PORTS-1:0]   conv_fulld_o,
  output logic [NUM_PORTS-1:0]   conv_enable_o,
  output logic [NUM_PORTS-1:0]   sw_speed_ovr_o,
  output logic [NUM_PORTS-1:0]   sw_dup_ovr_o
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_PORT0 = ADDR_W'(OFS_PORT0);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PORT0 + 4 * NUM_PORTS);
  localparam logic [ADDR_W-1:0] A_REL   = ADDR_W'(OFS_REL);
  localparam logic [ADDR_W-1:0] A_SWSPD = ADDR_W'(OFS_SWSPD);
  localparam logic [ADDR_W-1:0] A_SWDUP = ADDR_W'(OFS_SWDUP);

  logic                    key_open, prot_err, mode_take;
  logic                    port_hit;
  logic [ADDR_W-1:0]       port_off;
  logic [IDX_W-1:0]        port_idx;
  logic [32*NUM_PORTS-1:0] ctrl_flat;
  logic [31:0]             rd_val;

  assign port_off = bus_addr - A_PORT0;
  assign port_idx = IDX_W'(port_off >> 2);
  assign port_hit = (bus_addr >= A_PORT0) && (bus_addr < A_PEND) &&
                    (bus_addr[1:0] == 2'b00);

  mcr_key_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (bus_we && bus_addr == A_CMD),
    .mode_we   (bus_we && bus_addr == A_MODE),
    .wdata     (bus_wdata),
    .open_q    (key_open),
    .perr_q    (prot_err),
    .mode_take (mode_take)
  );

  mcr_port_bank #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_ports (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (bus_we && port_hit),
    .ctrl_idx     (port_idx),
    .rel_we       (bus_we && bus_addr == A_REL),
    .wdata        (bus_wdata),
    .ctrl_flat    (ctrl_flat),
    .rel_q        (conv_enable_o),
    .conv_speed_o (conv_speed_o),
    .conv_if_o    (conv_if_o),
    .conv_fulld_o (conv_fulld_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_mode_o      <= '0;
      sw_speed_ovr_o <= '0;
      sw_dup_ovr_o   <= '0;
    end else begin
      if (mode_take) sw_mode_o <= bus_wdata[4:0];
      if (bus_we && bus_addr == A_SWSPD) sw_speed_ovr_o <= bus_wdata[NUM_PORTS-1:0];
      if (bus_we && bus_addr == A_SWDUP) sw_dup_ovr_o   <= bus_wdata[NUM_PORTS-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_CMD)        rd_val[1:0] = {prot_err, key_open};
    else if (bus_addr == A_ID)    rd_val = ID_CODE;
    else if (bus_addr == A_MODE)  rd_val[4:0] = sw_mode_o;
    else if (port_hit)            rd_val = ctrl_flat[32*int'(port_idx) +: 32];
    else if (bus_addr == A_REL)   rd_val[NUM_PORTS-1:0] = conv_enable_o;
    else if (bus_addr == A_SWSPD) rd_val[NUM_PORTS-1:0] = sw_speed_ovr_o;
    else if (bus_addr == A_SWDUP) rd_val[NUM_PORTS-1:0] = sw_dup_ovr_o;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_val : '0;
  end
endmodule

// File: rtl/mcr_regbank_chk.sv
module mcr_regbank_chk
  import mcr_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W    = 12
)(
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic [31:0]          bus_rdata,
  input logic [4:0]           sw_mode_o,
  input logic [NUM_PORTS-1:0] conv_enable_o,
  input logic                 unlocked,
  input logic                 perr
);
  localparam logic [ADDR_W-1:0] C_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] C_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] C_REL  = ADDR_W'(OFS_REL);

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == 32'h0)) else $error("rdata not zero after idle");

  p_unlock_key_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(bus_we && bus_addr == C_CMD && bus_wdata == 32'h1))
    else $error("guard opened without final key");

  p_one_shot_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C_MODE) |=> !unlocked) else $error("guard stayed open");

  p_locked_write_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C_MODE && !unlocked) |=> ($stable(sw_mode_o) && perr))
    else $error("locked mode write took effect");

  p_perr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    perr |=> perr) else $error("error flag cleared");

  p_mode_legal_r7: assert property (@(posedge clk) disable iff (rst)
    !sw_mode_o[2] && !(sw_mode_o[4] && sw_mode_o[3])) else $error("illegal mode held");

  p_enable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == C_REL) |=> $stable(conv_enable_o))
    else $error("enable moved without release write");
endmodule

bind mcr_regbank mcr_regbank_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_we        (bus_we),
  .bus_re        (bus_re),
  .bus_rdata     (bus_rdata),
  .sw_mode_o     (sw_mode_o),
  .conv_enable_o (conv_enable_o),
  .unlocked      (key_open),
  .perr          (prot_err)
);

// File: tb/mcr_regbank_bench.sv
module mcr_regbank_bench;
  localparam int NP = 3;
  localparam int AW = 12;
  localparam logic [31:0] IDV = 32'h0051_A7C3;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0] sw_mode_o;
  logic [2*NP-1:0] conv_speed_o, conv_if_o;
  logic [NP-1:0] conv_fulld_o, conv_enable_o, sw_speed_ovr_o, sw_dup_ovr_o;

  int checks = 0, errors = 0;

  logic [4:0]  m_mode;
  logic [31:0] m_ctrl [NP];
  logic [NP-1:0] m_rel, m_spd, m_dup;
  logic m_open, m_perr;
  int m_step;

  always #10 clk = ~clk;

  mcr_regbank #(.NUM_PORTS(NP), .ADDR_W(AW), .ID_CODE(IDV)) u_mcr_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sw_mode_o(sw_mode_o), .conv_speed_o(conv_speed_o), .conv_if_o(conv_if_o),
    .conv_fulld_o(conv_fulld_o), .conv_enable_o(conv_enable_o),
    .sw_speed_ovr_o(sw_speed_ovr_o), .sw_dup_ovr_o(sw_dup_ovr_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] keyv(input int s);
    case (s)
      0: return 32'h0000_00A5;
      2: return 32'h0000_FFFE;
      default: return 32'h0000_0001;
    endcase
  endfunction

  function automatic bit legal(input logic [4:0] v);
    return (v <= 5'h03) || (v >= 5'h08 && v <= 5'h0B) || (v >= 5'h10 && v <= 5'h13);
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (a == 32'h000) return {30'b0, m_perr, m_open};
    if (a == 32'h004) return IDV;
    if (a == 32'h020) return {27'b0, m_mode};
    if (a >= 32'h100 && a < 32'h100 + 4*NP && a % 4 == 0) return m_ctrl[(a - 32'h100) / 4];
    if (a == 32'h114) return {{(32-NP){1'b0}}, m_rel};
    if (a == 32'h304) return {{(32-NP){1'b0}}, m_spd};
    if (a == 32'h308) return {{(32-NP){1'b0}}, m_dup};
    return 32'h0;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_mode = '0; m_rel = '0; m_spd = '0; m_dup = '0;
    m_open = 1'b0; m_perr = 1'b0; m_step = 0;
    for (int p = 0; p < NP; p++) m_ctrl[p] = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    if (a == 32'h000) begin
      m_open = 1'b0;
      if (d == keyv(m_step)) begin
        if (m_step == 3) begin m_open = 1'b1; m_step = 0; end
        else m_step++;
      end else m_step = (d == 32'hA5) ? 1 : 0;
    end else if (a == 32'h020) begin
      if (m_open && legal(d[4:0])) m_mode = d[4:0];
      else m_perr = 1'b1;
      m_open = 1'b0;
    end else if (a >= 32'h100 && a < 32'h100 + 4*NP && a % 4 == 0)
      m_ctrl[(a - 32'h100) / 4] = d & 32'h0000_F10F;
    else if (a == 32'h114) m_rel = d[NP-1:0];
    else if (a == 32'h304) m_spd = d[NP-1:0];
    else if (a == 32'h308) m_dup = d[NP-1:0];
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input int a);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp_rd(a));
  endtask

  task automatic unlock();
    wr(0, 32'hA5); wr(0, 32'h1); wr(0, 32'hFFFE); wr(0, 32'h1);
  endtask

  task automatic chk_outputs(input string tag);
    check({tag, " sw_mode_o"}, {27'b0, sw_mode_o}, {27'b0, m_mode});
    for (int p = 0; p < NP; p++) begin
      check({tag, " speed"}, {30'b0, conv_speed_o[2*p +: 2]}, {30'b0, m_ctrl[p][1:0]});
      check({tag, " if"},    {30'b0, conv_if_o[2*p +: 2]},    {30'b0, m_ctrl[p][3:2]});
      check({tag, " fulld"}, {31'b0, conv_fulld_o[p]},        {31'b0, m_ctrl[p][8]});
    end
    check({tag, " enable"}, {{(32-NP){1'b0}}, conv_enable_o}, {{(32-NP){1'b0}}, m_rel});
    check({tag, " spd ovr"}, {{(32-NP){1'b0}}, sw_speed_ovr_o}, {{(32-NP){1'b0}}, m_spd});
    check({tag, " dup ovr"}, {{(32-NP){1'b0}}, sw_dup_ovr_o}, {{(32-NP){1'b0}}, m_dup});
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 32'h400; a += 4) rd_chk(tag, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1: reset state everywhere, R11 unmapped zeros
    chk_outputs("R1 reset");
    sweep("R1 reset sweep");
    // R2: ID and idle read data
    rd_chk("R2 id", 4);
    @(negedge clk);
    check("R2 idle rdata", bus_rdata, 32'h0);

    // R6: locked write refused, sticky error
    wr(32'h20, 32'h3);
    chk_outputs("R6 locked");
    rd_chk("R6 perr", 0);
    wr(0, 32'h5); wr(32'h114, 32'h1);
    rd_chk("R6 perr sticky", 0);

    // R3 / R5: unlock, one write, relock
    do_reset();
    unlock();
    rd_chk("R3 open", 0);
    wr(32'h20, 32'h12);
    chk_outputs("R5 first write");
    rd_chk("R5 closed", 0);
    wr(32'h20, 32'h01);
    chk_outputs("R5 second refused");
    rd_chk("R5 perr", 0);

    // R4: restart behaviour
    do_reset();
    wr(0, 32'hA5); wr(0, 32'h1); wr(0, 32'hA5); wr(0, 32'h1); wr(0, 32'hFFFE); wr(0, 32'h1);
    rd_chk("R4 A5 restart", 0);
    wr(0, 32'hA5);
    rd_chk("R4 cmd closes guard", 0);
    do_reset();
    wr(0, 32'hA5); wr(0, 32'h1); wr(0, 32'hFFFE); wr(0, 32'h2);
    rd_chk("R4 bad last key", 0);
    wr(0, 32'hA5); wr(0, 32'hFFFE); wr(0, 32'h1); wr(0, 32'h1);
    rd_chk("R4 skipped key", 0);
    wr(32'h20, 32'h1);
    chk_outputs("R4 still locked");

    // R7: exhaustive mode values
    for (int v = 0; v < 32; v++) begin
      do_reset();
      unlock();
      wr(32'h20, 32'hFFFF_FFE0 | 32'(v));
      chk_outputs("R7 mode value");
      rd_chk("R7 perr/open", 0);
      rd_chk("R7 mode read", 32'h20);
    end

    // R8: every field combination on every port, reserved bits set
    do_reset();
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < 32; c++) begin
        wr(32'h100 + 4*p, 32'hFFFF_0EF0 | 32'(c % 16) << 12 | 32'(c[4]) << 8 | 32'(c[3:0]));
        chk_outputs("R8 port word");
        rd_chk("R8 readback", 32'h100 + 4*p);
      end
    sweep("R8 sweep");

    // R9: every release mask
    for (int v = 0; v < 32; v++) begin
      wr(32'h114, 32'hFFFF_FFE0 | 32'(v));
      chk_outputs("R9 release");
      rd_chk("R9 readback", 32'h114);
    end

    // R10: switch overrides
    wr(32'h304, 32'hFFFF_FFFF); wr(32'h308, 32'h0000_0005);
    chk_outputs("R10 set");
    rd_chk("R10 spd", 32'h304); rd_chk("R10 dup", 32'h308);
    wr(32'h304, 32'h0); wr(32'h308, 32'h0);
    chk_outputs("R10 clear");

    // R11: unmapped and misaligned writes change nothing; reads have no effect
    wr(32'h304, 32'h2);
    unlock();
    wr(32'h10C, 32'hFFFF_FFFF); wr(32'h102, 32'hFFFF_FFFF); wr(32'h8, 32'hFFFF_FFFF);
    wr(32'h24, 32'hFFFF_FFFF); wr(32'h118, 32'hFFFF_FFFF); wr(32'h305, 32'hFFFF_FFFF);
    chk_outputs("R11 unmapped writes");
    sweep("R11 sweep 1");
    rd_chk("R11 misaligned", 32'h101);
    rd_chk("R11 misaligned", 32'h306);
    sweep("R11 sweep 2");
    wr(32'h20, 32'h9);
    chk_outputs("R11 guard kept open");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule